// File: doc/BRIEF.md
# TIC Strobe and Interrupt Timing Controller

This block produces the periodic measurement strobe (TIC) and the processor interrupt line for a multi-channel satellite-navigation correlator. A free-running internal counter divides the master clock by one of two fixed, non-power-of-two lengths. The long length gives roughly a 100 ms TIC and the short length roughly 9.09 ms at a 175 ns master clock. The TIC can instead be slaved to a companion device through an external input. Each TIC raises an on-chip interrupt pulse.

A qualifying interrupt edge produces a single-cycle status-latch strobe. The edge comes from the on-chip pulse or from a companion device's interrupt input, and its polarity is set by the bus-mode flag. The strobe tells neighbouring logic when to capture its status bits. A four-bit control word, written in one cycle, chooses the period, the TIC source, the interrupt source and whether the interrupt is enabled. Reset clears the whole control word.

Top module: `tic_irq_ctrl`

## Requirements
- R1: With control bit 0 low, `tic_out` pulses once every LONG_CYC clock cycles, driven by the internal counter.
- R2: With control bit 0 high, `tic_out` pulses once every SHORT_CYC clock cycles.
- R3: When a write changes bit 0, the internal counter restarts. The first `tic_out` after the change comes SHORT_CYC+2 (or LONG_CYC+2) clock edges after the edge that stores the write.
- R4: Every `tic_out` pulse lasts exactly one clock cycle.
- R5: With control bit 2 high, each rising edge of `ext_tic_in` gives exactly one `tic_out` pulse, on the third clock edge after the first edge that samples the input high. Internal counter wraps then produce no pulse.
- R6: With control bit 1 low, `int_out` stays low and `status_latch` never pulses, whatever the interrupt source.
- R7: With bit 1 high, the on-chip interrupt drives `int_out` high from the second edge after a `tic_out` pulse, for INT_WIDTH cycles.
- R8: With bit 1 high, bit 3 low and `bus_neg_edge` low, `status_latch` pulses for one cycle on the rising edge of the on-chip interrupt, two edges after the `tic_out` pulse.
- R9: With `bus_neg_edge` high, `status_latch` pulses on the falling edge of the on-chip interrupt instead, INT_WIDTH+2 edges after the `tic_out` pulse.
- R10: With bit 3 high, `status_latch` follows the rising (or falling) edge of `ext_int_in`, on the third edge after the first edge that samples the new level. On-chip interrupt edges then do not latch.
- R11: Reset clears all four control bits, selecting the long period, internal TIC, on-chip interrupt source and a disabled interrupt. All outputs are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 4 | Control word: bit0 short period, bit1 interrupt enable, bit2 external TIC, bit3 external interrupt source |
| bus_neg_edge | input | 1 | Bus mode: low latches on rising interrupt edge, high on falling |
| ext_tic_in | input | 1 | Asynchronous TIC from a companion device |
| ext_int_in | input | 1 | Asynchronous interrupt from a companion device |
| tic_out | output | 1 | Single-cycle TIC strobe |
| int_out | output | 1 | Interrupt output pin |
| status_latch | output | 1 | Single-cycle status capture strobe |

## Verification
The assertions take three things for granted. Both period lengths are at least two cycles. `bus_neg_edge` is quasi-static. The external inputs hold each level for at least one clock, so that the synchronizer never yields two like edges in a row. The bench changes `bus_neg_edge` only while no interrupt pulse is in flight. It holds each external level for several cycles, and it issues period-changing writes just after a TIC, so that no counter wrap coincides with the write.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int CTRL_W = 4;

  // packed LSB first at the bottom: rate_short is bit 0
  typedef struct packed {
    logic irq_ext;     // bit 3: interrupt edge from companion input
    logic tic_ext;     // bit 2: TIC from companion input
    logic irq_en;      // bit 1: interrupt output and latching enabled
    logic rate_short;  // bit 0: short period selected
  } tic_ctrl_t;
endpackage

// File: rtl/tic_sync_edge.sv
module tic_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      s3   <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      s1   <= async_in;
      s2   <= s1;
      s3   <= s2;
      rise <= s2 & ~s3;
      fall <= ~s2 & s3;
    end
  end

  a_r5_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));
  a_r5_rise_spaced: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tic_period_gen.sv
module tic_period_gen #(
  parameter int LONG_CYC  = 571428,
  parameter int SHORT_CYC = 51948
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_short,
  output logic tick
);
  localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW      = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CW-1:0] LAST_LONG  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(SHORT_CYC - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          prev_short;
  logic          rate_changed;

  assign last         = rate_short ? LAST_SHORT : LAST_LONG;
  assign rate_changed = rate_short ^ prev_short;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      prev_short <= 1'b0;
      tick       <= 1'b0;
    end else begin
      prev_short <= rate_short;
      if (rate_changed) begin
        cnt  <= '0;
        tick <= 1'b0;
      end else if (cnt == last) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end
  end

  a_r4_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_LONG || cnt <= LAST_SHORT);
  a_r3_restart_after_change: assert property (@(posedge clk) disable iff (rst)
    rate_changed |=> !tick);
endmodule

// File: rtl/tic_irq_core.sv
module tic_irq_core #(
  parameter int INT_WIDTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tic_stb,
  input  logic irq_en,
  input  logic irq_ext,
  input  logic neg_mode,
  input  logic ext_rise,
  input  logic ext_fall,
  output logic int_pin,
  output logic latch_stb
);
  localparam int WCW = $clog2(INT_WIDTH + 1);

  logic [WCW-1:0] wcnt;
  logic           int_lvl;
  logic           int_lvl_d;
  logic           own_rise;
  logic           own_fall;
  logic           edge_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_lvl <= 1'b0;
      wcnt    <= '0;
    end else if (tic_stb) begin
      int_lvl <= 1'b1;
      wcnt    <= WCW'(INT_WIDTH - 1);
    end else if (wcnt != '0) begin
      wcnt    <= wcnt - 1'b1;
    end else begin
      int_lvl <= 1'b0;
    end
  end

  assign own_rise = int_lvl & ~int_lvl_d;
  assign own_fall = ~int_lvl & int_lvl_d;

  always_comb begin
    if (irq_ext) edge_hit = neg_mode ? ext_fall : ext_rise;
    else         edge_hit = neg_mode ? own_fall : own_rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_lvl_d <= 1'b0;
      int_pin   <= 1'b0;
      latch_stb <= 1'b0;
    end else begin
      int_lvl_d <= int_lvl;
      int_pin   <= irq_en & int_lvl;
      latch_stb <= irq_en & edge_hit;
    end
  end

  a_r7_pulse_needs_tic: assert property (@(posedge clk) disable iff (rst)
    $rose(int_lvl) |-> $past(tic_stb));
  a_r6_masked_pin_low: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !int_pin);
  a_r8_latch_single: assert property (@(posedge clk) disable iff (rst)
    latch_stb |=> !latch_stb);
endmodule

// File: rtl/tic_irq_ctrl.sv
module tic_irq_ctrl
  import tic_pkg::*;
#(
  parameter int LONG_CYC  = 571428,
  parameter int SHORT_CYC = 51948,
  parameter int INT_WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              bus_neg_edge,
  input  logic              ext_tic_in,
  input  logic              ext_int_in,
  output logic              tic_out,
  output logic              int_out,
  output logic              status_latch
);
  localparam int N_EXT = 2;  // index 0: TIC, index 1: interrupt

  tic_ctrl_t        ctrl;
  logic [N_EXT-1:0] ext_raw;
  logic [N_EXT-1:0] ext_rise;
  logic [N_EXT-1:0] ext_fall;
  logic             own_tick;

  always_ff @(posedge clk) begin
    if (rst)         ctrl <= '0;
    else if (cfg_we) ctrl <= tic_ctrl_t'(cfg_wdata);
  end

  assign ext_raw = {ext_int_in, ext_tic_in};

  for (genvar i = 0; i < N_EXT; i++) begin : g_sync
    tic_sync_edge u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (ext_raw[i]),
      .rise     (ext_rise[i]),
      .fall     (ext_fall[i])
    );
  end

  tic_period_gen #(
    .LONG_CYC  (LONG_CYC),
    .SHORT_CYC (SHORT_CYC)
  ) u_period (
    .clk        (clk),
    .rst        (rst),
    .rate_short (ctrl.rate_short),
    .tick       (own_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) tic_out <= 1'b0;
    else     tic_out <= ctrl.tic_ext ? ext_rise[0] : own_tick;
  end

  tic_irq_core #(
    .INT_WIDTH (INT_WIDTH)
  ) u_irq (
    .clk       (clk),
    .rst       (rst),
    .tic_stb   (tic_out),
    .irq_en    (ctrl.irq_en),
    .irq_ext   (ctrl.irq_ext),
    .neg_mode  (bus_neg_edge),
    .ext_rise  (ext_rise[1]),
    .ext_fall  (ext_fall[1]),
    .int_pin   (int_out),
    .latch_stb (status_latch)
  );

  a_r6_no_latch_masked: assert property (@(posedge clk) disable iff (rst)
    !ctrl.irq_en |=> !status_latch);
  a_r5_ext_tic_source: assert property (@(posedge clk) disable iff (rst)
    (ctrl.tic_ext && !ext_rise[0]) |=> !tic_out);
  a_r11_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (ctrl == '0));
endmodule

// File: tb/tic_irq_ctrl_bench.sv
module tic_irq_ctrl_bench;
  localparam int L = 40;
  localparam int S = 16;
  localparam int W = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic       bus_neg_edge = 1'b0;
  logic       ext_tic_in = 1'b0;
  logic       ext_int_in = 1'b0;
  logic       tic_out, int_out, status_latch;

  int cyc = 0;
  int nchk = 0, nfail = 0;
  int tic_n = 0, tic_last = 0, tic_double = 0;
  int latch_n = 0, latch_last = 0;
  int int_hi_n = 0;
  logic tic_prev = 1'b0;

  always #10 clk = ~clk;

  tic_irq_ctrl #(.LONG_CYC(L), .SHORT_CYC(S), .INT_WIDTH(W)) u_tic_irq_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .bus_neg_edge(bus_neg_edge), .ext_tic_in(ext_tic_in),
    .ext_int_in(ext_int_in), .tic_out(tic_out), .int_out(int_out),
    .status_latch(status_latch)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tic_out) begin
      tic_n++;
      tic_last = cyc;
      if (tic_prev) tic_double++;
    end
    tic_prev = tic_out;
    if (status_latch) begin
      latch_n++;
      latch_last = cyc;
    end
    if (int_out) int_hi_n++;
  end

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tic(string req);
    int n0 = tic_n;
    int k = 0;
    while (tic_n == n0 && k < 4 * L) begin
      @(negedge clk);
      k++;
    end
    chk(req, "tic seen", int'(tic_n != n0), 1);
  endtask

  task automatic wr(logic [3:0] v, output int c);
    @(negedge clk);
    cfg_wdata = v;
    cfg_we = 1'b1;
    c = cyc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset(string req);
    rst = 1'b1;
    idle(3);
    chk(req, "tic_out in reset", int'(tic_out), 0);
    chk(req, "int_out in reset", int'(int_out), 0);
    chk(req, "status_latch in reset", int'(status_latch), 0);
    rst = 1'b0;
  endtask

  task automatic t_long_period();
    int t0;
    wait_tic("R1");
    t0 = tic_last;
    wait_tic("R1");
    chk("R1", "long interval", tic_last - t0, L);
  endtask

  task automatic t_masked();
    int i0 = int_hi_n;
    int l0 = latch_n;
    wait_tic("R6");
    idle(W + 4);
    chk("R6", "int_out while masked", int_hi_n - i0, 0);
    chk("R6", "latch while masked", latch_n - l0, 0);
  endtask

  task automatic t_short();
    int c, t0;
    wait_tic("R3");
    wr(4'b0001, c);
    wait_tic("R3");
    chk("R3", "first tic after change", tic_last - c, S + 3);
    t0 = tic_last;
    wait_tic("R2");
    chk("R2", "short interval", tic_last - t0, S);
  endtask

  task automatic t_int_edge(logic neg, string req);
    int c, a, i0, l0;
    bus_neg_edge = neg;
    wr(4'b0011, c);
    wait_tic(req);
    a = tic_last;
    i0 = int_hi_n;
    l0 = latch_n;
    idle(W + 4);
    chk("R7", "int_out high cycles", int_hi_n - i0, W);
    chk(req, "latch count", latch_n - l0, 1);
    chk(req, "latch timing", latch_last - a, neg ? W + 2 : 2);
  endtask

  task automatic t_ext_int();
    int c, l0;
    bus_neg_edge = 1'b0;
    wr(4'b1011, c);
    l0 = latch_n;
    wait_tic("R10");
    idle(W + 4);
    chk("R10", "own interrupt ignored", latch_n - l0, 0);
    @(negedge clk);
    ext_int_in = 1'b1;
    c = cyc;
    idle(6);
    chk("R10", "latch on ext rise", latch_n - l0, 1);
    chk("R10", "ext rise timing", latch_last - c, 4);
    ext_int_in = 1'b0;
    idle(6);
    chk("R10", "no latch on ext fall", latch_n - l0, 1);
    bus_neg_edge = 1'b1;
    idle(2);
    @(negedge clk);
    ext_int_in = 1'b1;
    idle(6);
    chk("R10", "no latch on rise in neg mode", latch_n - l0, 1);
    @(negedge clk);
    ext_int_in = 1'b0;
    c = cyc;
    idle(6);
    chk("R10", "latch on ext fall in neg mode", latch_last - c, 4);
    bus_neg_edge = 1'b0;
    wr(4'b1001, c);
    l0 = latch_n;
    @(negedge clk);
    ext_int_in = 1'b1;
    idle(6);
    ext_int_in = 1'b0;
    idle(6);
    chk("R6", "ext interrupt masked", latch_n - l0, 0);
  endtask

  task automatic t_ext_tic();
    int c, n0;
    wr(4'b0101, c);
    idle(2);
    n0 = tic_n;
    idle(3 * S);
    chk("R5", "internal tic suppressed", tic_n - n0, 0);
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      ext_tic_in = 1'b1;
      c = cyc;
      idle(8);
      chk("R5", "one tic per ext rise", tic_n - n0, p + 1);
      chk("R5", "ext tic timing", tic_last - c, 4);
      ext_tic_in = 1'b0;
      idle(5);
    end
  endtask

  task automatic t_reset_defaults();
    int t0, i0;
    t_reset("R11");
    i0 = int_hi_n;
    wait_tic("R11");
    t0 = tic_last;
    wait_tic("R11");
    chk("R11", "period back to long", tic_last - t0, L);
    chk("R11", "interrupt disabled", int_hi_n - i0, 0);
  endtask

  initial begin
    t_reset("R11");
    t_long_period();
    t_masked();
    t_short();
    t_int_edge(1'b0, "R8");
    t_int_edge(1'b1, "R9");
    t_ext_int();
    t_ext_tic();
    t_reset_defaults();
    chk("R4", "tic pulses wider than one cycle", tic_double, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #400000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule